// File: doc/BRIEF.md
# Counter-Mode IV and Counter Block Register

This block stores the 128-bit initialization vector used by a block-cipher accelerator in counter mode, and it presents that vector to the cipher core as the input block for every data block. The least significant 32-bit word is the running counter. The three upper words form a nonce that does not change while the engine runs. Each time the core reports a finished data block, the counter steps by one. The step is modulo 2^32 and never carries into the nonce.

Software reaches the block through a small word-wide register bus. Addresses 0 to 3 hold the IV words, and address 0 is the least significant word, which holds the counter. Address 4 is a control word that carries the enable, the operating mode and the chaining mode. While the engine is enabled, the IV is locked: writes to it are dropped and reads of it return zero. Once the engine is disabled, reads return the live counter, so a message can be suspended and resumed later. If the control word asks for a key-derivation-plus-decrypt mode together with counter chaining, that mode is quietly replaced by counter decrypt. The direction output tells the core to run forward whenever counter chaining is selected.

Top module: `ctr_iv_unit`

## Requirements
- R1: After reset, all four IV words read 0, the control word reads 0, and `ctr_block_o` is 0.
- R2: While enable is 0, a write to address 0, 1, 2 or 3 stores that 32-bit word. Address 0 drives `ctr_block_o[31:0]` and address 3 drives `ctr_block_o[127:96]`.
- R3: While enable is 1 and the chaining field is 2'b10 (counter), each cycle with `blk_done_i` high adds one to `ctr_block_o[31:0]`. The new value appears on the cycle after the strobe edge.
- R4: The counter goes from 0xFFFFFFFF to 0x00000000, and `ctr_block_o[127:32]` stays unchanged.
- R5: While enable is 1, writes to addresses 0 to 3 are dropped and `ctr_block_o` is not affected.
- R6: While enable is 1, a read of addresses 0 to 3 returns 0x00000000.
- R7: While enable is 0, a read of addresses 0 to 3 returns the stored word, including every counter step made so far.
- R8: The control word at address 4 has enable in bit 0, mode in bits 2:1 and chaining in bits 4:3, and reads back in the same layout. A write with chaining 2'b10 and mode 2'b11 stores mode 2'b10.
- R9: `core_fwd_o` is 1 when chaining is 2'b10 or mode is 2'b00, and 0 otherwise.
- R10: `blk_done_i` has no effect while enable is 0 or while chaining is not 2'b10.
- R11: `ctr_block_o` always shows the full stored 128-bit IV. Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address, used for both writes and reads |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| blk_done_i | input | 1 | One-cycle strobe from the core at the end of each data block |
| ctr_block_o | output | 128 | Current counter block sent to the cipher core |
| core_fwd_o | output | 1 | 1 selects the forward (encrypt) direction in the core |

## Verification
The counter is seeded at 0xFFFFFFFE with distinct nonce words and then stepped three times. This shows whether the wrap stays inside the low word, and whether any carry leaks into bit 32. Writes and reads are attempted in both the locked state and the unlocked state. These cases separate a lock that really drops writes from one that only hides reads, and they show that the post-suspend read returns the stepped counter rather than the seed value. Control writes cover mode 11 under counter chaining, mode 11 under chaining mode 2'b01, and mode 00 under chaining mode 2'b00. Together these tell the coercion rule apart from an unconditional remap, and they confirm the direction output in each case. Block-done strobes are also sent while disabled and under non-counter chaining, to check that those strobes are ignored.

// File: rtl/ctr_iv_pkg.sv
package ctr_iv_pkg;

    typedef enum logic [1:0] {
        CH_ECB = 2'b00,
        CH_CBC = 2'b01,
        CH_CTR = 2'b10,
        CH_RSV = 2'b11
    } chain_e;

    typedef enum logic [1:0] {
        MD_ENC    = 2'b00,
        MD_KEY    = 2'b01,
        MD_DEC    = 2'b10,
        MD_KEYDEC = 2'b11
    } mode_e;

    localparam int unsigned CTRL_EN_BIT = 0;
    localparam int unsigned MODE_LSB    = 1;
    localparam int unsigned CHAIN_LSB   = 3;
    localparam int unsigned CTRL_USED_W = 5;

    typedef struct packed {
        logic   en;
        mode_e  mode;
        chain_e chain;
    } ctrl_t;

    function automatic mode_e coerce_mode(chain_e ch, mode_e md);
        if (ch == CH_CTR && md == MD_KEYDEC) begin
            return MD_DEC;
        end
        return md;
    endfunction

endpackage

// File: rtl/ctr_iv_ctrl.sv
module ctr_iv_ctrl
    import ctr_iv_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned CTRL_ADDR = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output ctrl_t             ctrl_o
);

    typedef struct packed {
        ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;
    chain_e new_chain;
    mode_e  new_mode;
    logic   unused_hi;

    assign new_chain = chain_e'(wr_data_i[CHAIN_LSB +: 2]);
    assign new_mode  = mode_e'(wr_data_i[MODE_LSB +: 2]);
    assign unused_hi = ^wr_data_i[WORD_W-1:CTRL_USED_W];

    always_comb begin
        st_d = st_q;
        if (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR)) begin
            st_d.ctrl.en    = wr_data_i[CTRL_EN_BIT];
            st_d.ctrl.chain = new_chain;
            st_d.ctrl.mode  = coerce_mode(new_chain, new_mode);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/ctr_iv_store.sv
module ctr_iv_store #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned CTR_WORDS = 1,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              wr_en_i,
    input  logic [ADDR_W-1:0]                 wr_addr_i,
    input  logic [WORD_W-1:0]                 wr_data_i,
    input  logic                              lock_i,
    input  logic                              adv_i,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words_o
);

    localparam int unsigned IV_W  = NUM_WORDS * WORD_W;
    localparam int unsigned CTR_W = CTR_WORDS * WORD_W;

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    } state_t;

    state_t st_d, st_q;
    logic [NUM_WORDS-1:0] hit;
    logic [IV_W-1:0]      flat_q;
    logic [CTR_W-1:0]     ctr_next;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_hit
        assign hit[g] = wr_en_i && !lock_i && (wr_addr_i == ADDR_W'(g));
    end

    assign flat_q   = st_q.words;
    assign ctr_next = flat_q[CTR_W-1:0] + CTR_W'(1);

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.words = {flat_q[IV_W-1:CTR_W], ctr_next};
        end
        for (int i = 0; i < int'(NUM_WORDS); i++) begin
            if (hit[i]) begin
                st_d.words[i] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words_o = st_q.words;

endmodule

// File: rtl/ctr_iv_rdmux.sv
module ctr_iv_rdmux
    import ctr_iv_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned CTRL_ADDR = 4
) (
    input  logic [ADDR_W-1:0]                rd_addr_i,
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_i,
    input  ctrl_t                            ctrl_i,
    output logic [WORD_W-1:0]                rdata_o
);

    localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    always_comb begin
        rdata_o = '0;
        if (rd_addr_i < ADDR_W'(NUM_WORDS)) begin
            if (!ctrl_i.en) begin
                rdata_o = words_i[rd_addr_i[IDX_W-1:0]];
            end
        end else if (rd_addr_i == ADDR_W'(CTRL_ADDR)) begin
            rdata_o[CTRL_EN_BIT]     = ctrl_i.en;
            rdata_o[MODE_LSB +: 2]   = ctrl_i.mode;
            rdata_o[CHAIN_LSB +: 2]  = ctrl_i.chain;
        end
    end

endmodule

// File: rtl/ctr_iv_unit.sv
module ctr_iv_unit
    import ctr_iv_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned CTR_WORDS = 1,
    parameter int unsigned ADDR_W    = 3
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        bus_we_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [WORD_W-1:0]           bus_wdata_i,
    output logic [WORD_W-1:0]           bus_rdata_o,
    input  logic                        blk_done_i,
    output logic [NUM_WORDS*WORD_W-1:0] ctr_block_o,
    output logic                        core_fwd_o
);

    localparam int unsigned CTRL_ADDR = NUM_WORDS;

    ctrl_t                            ctrl;
    logic [NUM_WORDS-1:0][WORD_W-1:0] iv_words;
    logic                             ctl_en;
    logic [1:0]                       ctl_mode;
    logic [1:0]                       ctl_chain;
    logic                             adv;

    ctr_iv_ctrl #(
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (bus_we_i),
        .wr_addr_i(bus_addr_i),
        .wr_data_i(bus_wdata_i),
        .ctrl_o   (ctrl)
    );

    assign ctl_en    = ctrl.en;
    assign ctl_mode  = ctrl.mode;
    assign ctl_chain = ctrl.chain;
    assign adv       = ctl_en && (ctl_chain == CH_CTR) && blk_done_i;

    ctr_iv_store #(
        .WORD_W   (WORD_W),
        .NUM_WORDS(NUM_WORDS),
        .CTR_WORDS(CTR_WORDS),
        .ADDR_W   (ADDR_W)
    ) u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (bus_we_i),
        .wr_addr_i(bus_addr_i),
        .wr_data_i(bus_wdata_i),
        .lock_i   (ctl_en),
        .adv_i    (adv),
        .words_o  (iv_words)
    );

    ctr_iv_rdmux #(
        .WORD_W   (WORD_W),
        .NUM_WORDS(NUM_WORDS),
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_rdmux (
        .rd_addr_i(bus_addr_i),
        .words_i  (iv_words),
        .ctrl_i   (ctrl),
        .rdata_o  (bus_rdata_o)
    );

    assign ctr_block_o = iv_words;
    assign core_fwd_o  = (ctl_chain == CH_CTR) || (ctl_mode == MD_ENC);

endmodule

// File: rtl/ctr_iv_chk.sv
module ctr_iv_chk #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned NUM_WORDS = 4,
    parameter int unsigned CTR_WORDS = 1,
    parameter int unsigned ADDR_W    = 3
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        bus_we_i,
    input logic [ADDR_W-1:0]           bus_addr_i,
    input logic [WORD_W-1:0]           bus_rdata_i,
    input logic                        blk_done_i,
    input logic [NUM_WORDS*WORD_W-1:0] ctr_block_i,
    input logic                        core_fwd_i,
    input logic                        en_i,
    input logic [1:0]                  mode_i,
    input logic [1:0]                  chain_i
);

    localparam int unsigned IV_W  = NUM_WORDS * WORD_W;
    localparam int unsigned CTR_W = CTR_WORDS * WORD_W;

    logic iv_addr;
    assign iv_addr = bus_addr_i < ADDR_W'(NUM_WORDS);

    // R3: one step per strobe while running in counter chaining
    a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && chain_i == 2'b10 && blk_done_i |=>
        ctr_block_i[CTR_W-1:0] == CTR_W'($past(ctr_block_i[CTR_W-1:0]) + CTR_W'(1)));

    // R4: nonce words hold while enabled
    a_r4_nonce_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> $stable(ctr_block_i[IV_W-1:CTR_W]));

    // R5: locked write leaves the block untouched
    a_r5_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && bus_we_i && iv_addr && !blk_done_i |=> $stable(ctr_block_i));

    // R6: IV reads hidden while enabled
    a_r6_rd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && iv_addr |-> bus_rdata_i == '0);

    // R8: key-derive-decrypt never stored under counter chaining
    a_r8_no_keydec: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chain_i == 2'b10 |-> mode_i != 2'b11);

    // R9: counter chaining forces the forward direction
    a_r9_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chain_i == 2'b10 |-> core_fwd_i);

    // R10: idle and unwritten means no change
    a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i && !bus_we_i |=> $stable(ctr_block_i));

endmodule

bind ctr_iv_unit ctr_iv_chk #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS),
    .CTR_WORDS(CTR_WORDS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_rdata_i(bus_rdata_o),
    .blk_done_i (blk_done_i),
    .ctr_block_i(ctr_block_o),
    .core_fwd_i (core_fwd_o),
    .en_i       (ctl_en),
    .mode_i     (ctl_mode),
    .chain_i    (ctl_chain)
);

// File: tb/ctr_iv_unit_tb.sv
`timescale 1ns/100ps
module ctr_iv_unit_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         we = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [31:0]  wdata = 32'd0;
    logic         done = 1'b0;
    logic [31:0]  rdata;
    logic [127:0] blk;
    logic         fwd;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [31:0] m_iv [4];
    bit          m_en;
    bit [1:0]    m_mode;
    bit [1:0]    m_chain;

    always #2 clk = ~clk;

    ctr_iv_unit u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bus_we_i   (we),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .blk_done_i (done),
        .ctr_block_o(blk),
        .core_fwd_o (fwd)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [2:0] a);
        if (a < 3'd4) return m_en ? 32'd0 : m_iv[a[1:0]];
        if (a == 3'd4) return {27'd0, m_chain, m_mode, m_en};
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_iv[i] <= 32'd0;
            m_en <= 1'b0; m_mode <= 2'd0; m_chain <= 2'd0;
        end else begin
            if (we && addr < 3'd4 && !m_en) m_iv[addr[1:0]] <= wdata;
            if (we && addr == 3'd4) begin
                m_en    <= wdata[0];
                m_chain <= wdata[4:3];
                m_mode  <= (wdata[4:3] == 2'b10 && wdata[2:1] == 2'b11) ? 2'b10 : wdata[2:1];
            end
            if (m_en && m_chain == 2'b10 && done) m_iv[0] <= m_iv[0] + 32'd1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R11 block vs model", blk, {m_iv[3], m_iv[2], m_iv[1], m_iv[0]});
            check("R9 direction vs model", {127'd0, fwd},
                  {127'd0, (m_chain == 2'b10) || (m_mode == 2'b00)});
            check("R7 read vs model", {96'd0, rdata}, {96'd0, m_read(addr)});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic pulse();
        done = 1'b1;
        @(posedge clk); #1;
        done = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        @(negedge clk);
        check(tag, {96'd0, rdata}, {96'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 5; a++) rd_chk("R1 reset read", 3'(a), 32'd0);
        check("R1 reset block", blk, 128'd0);

        // R2 load IV while disabled
        wr(3'd0, 32'hFFFF_FFFE);
        wr(3'd1, 32'h1111_1111);
        wr(3'd2, 32'h2222_2222);
        wr(3'd3, 32'h3333_3333);
        rd_chk("R2 word0", 3'd0, 32'hFFFF_FFFE);
        rd_chk("R2 word3", 3'd3, 32'h3333_3333);
        check("R2 block order", blk, 128'h33333333_22222222_11111111_FFFFFFFE);

        // enable, counter chaining, mode encrypt
        wr(3'd4, 32'h0000_0011);
        rd_chk("R8 ctrl readback", 3'd4, 32'h11);
        rd_chk("R6 read locked word0", 3'd0, 32'd0);
        rd_chk("R6 read locked word2", 3'd2, 32'd0);

        // R5 locked write dropped
        wr(3'd3, 32'hDEAD_BEEF);
        wr(3'd0, 32'h0000_0005);
        @(negedge clk);
        check("R5 locked write ignored", blk, 128'h33333333_22222222_11111111_FFFFFFFE);

        // R3 and R4 stepping across the wrap
        pulse();
        @(negedge clk);
        check("R3 step to max", blk, 128'h33333333_22222222_11111111_FFFFFFFF);
        pulse();
        @(negedge clk);
        check("R4 wrap to zero", blk, 128'h33333333_22222222_11111111_00000000);
        pulse();
        @(negedge clk);
        check("R3 step after wrap", blk, 128'h33333333_22222222_11111111_00000001);
        // back-to-back strobes
        done = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        done = 1'b0;
        @(negedge clk);
        check("R3 back-to-back", blk, 128'h33333333_22222222_11111111_00000003);

        // suspend: disable, keep counter chaining
        wr(3'd4, 32'h0000_0010);
        rd_chk("R7 live counter read", 3'd0, 32'h0000_0003);
        rd_chk("R7 nonce read", 3'd1, 32'h1111_1111);
        pulse();
        @(negedge clk);
        check("R10 strobe while disabled", blk, 128'h33333333_22222222_11111111_00000003);

        // R8 coercion under counter chaining
        wr(3'd4, 32'h0000_0016);
        rd_chk("R8 mode 11 coerced", 3'd4, 32'h14);
        check("R9 fwd under ctr", {127'd0, fwd}, 128'd1);

        // non-counter chaining keeps mode 11 and runs backward
        wr(3'd4, 32'h0000_000E);
        rd_chk("R8 mode 11 kept under cbc", 3'd4, 32'h0E);
        check("R9 reverse under cbc", {127'd0, fwd}, 128'd0);
        wr(3'd4, 32'h0000_000F);
        pulse();
        @(negedge clk);
        check("R10 strobe under cbc", blk, 128'h33333333_22222222_11111111_00000003);

        // ecb encrypt: forward
        wr(3'd4, 32'h0000_0000);
        @(negedge clk);
        check("R9 fwd under ecb enc", {127'd0, fwd}, 128'd1);
        rd_chk("R11 unmapped addr", 3'd6, 32'd0);

        // resume: rewrite counter while disabled
        wr(3'd0, 32'h0000_0100);
        rd_chk("R2 counter reload", 3'd0, 32'h0000_0100);

        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule